// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a synchronous model of the command front end of a parallel NOR flash. It watches single-cycle bus writes, each made of an address, a data word and a write strobe, and tracks the unlock handshakes that guard every command. It turns a completed handshake into one of the following actions:

- start a whole-chip erase;
- start a sector erase, which carries the sector number;
- enter identifier-read mode;
- return to array-read mode.

The block also selects what a bus read returns. In array mode the read carries the memory array data through unchanged. In identifier mode the read returns the manufacturer or device code. While an erase runs, or after it has failed, the read returns a status byte.

The erase itself runs in an external engine. The block starts that engine with a one-cycle pulse, and the engine reports back on a done input and a fail input. Writing F0h always brings the block back to array reads. If an erase is running or has failed at that moment, the same write also raises a one-cycle abort request toward the engine.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the read select is array (`rd_sel`=0), `busy` is low, and `erase_start` and `abort_req` are low.
- R2: In array mode `rd_data` equals `array_rdata` in the same cycle, and reads leave the mode unchanged.
- R3: The writes AAh@0x555, 55h@0x2AA, 80h@0x555, AAh@0x555, 55h@0x2AA, 10h@0x555 raise `erase_start` for exactly one cycle after the final write, with `erase_chip`=1 and `erase_sector`=0. `busy` is high from that cycle on.
- R4: The same handshake ending in 30h, written to any address, starts a sector erase. In that case `erase_chip`=0 and `erase_sector` = write address bits [ADDR_W-1:SECT_LSB].
- R5: A write that does not match the next expected step returns the tracker to its start without starting anything. A new command must then begin again from the first unlock.
- R6: After the writes AAh@0x555, 55h@0x2AA, 90h@0x555, the block is in identifier mode (`rd_sel`=1). A read with address bits [1:0]=00 returns MFR_CODE (0x00C2), 01 returns DEV_CODE, and 10 or 11 returns 0.
- R7: Identifier mode lasts until F0h is written. F0h then returns the block to array mode.
- R8: While `busy` is high, `rd_sel`=2 and `rd_data` is a status byte. Bit 7 of that byte is 0, bit 6 inverts after every read, bit 5 is the failure flag, and all other bits are 0. Bit 6 starts at 0 when the erase starts.
- R9: While `busy` is high, every write except F0h is ignored. No erase starts and the mode stays as it is.
- R10: F0h written while `busy` is high raises `abort_req` for exactly one cycle after the write. The block then returns to array mode with `busy` low.
- R11: `erase_done` during a running erase returns the block to array mode. `erase_fail` during a running erase sets status bit 5, and `busy` stays high until F0h is written.
- R12: F0h written while `busy` is low gives array mode and clears any partial handshake, and it raises no `abort_req`.
- R13: Only the low byte of the write data and the low KEY_W (11) address bits are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe; one write per cycle in which it is high |
| bus_rd | input | 1 | Read strobe; advances the status toggle bit |
| bus_addr | input | ADDR_W | Word address for both reads and writes |
| bus_wdata | input | DATA_W | Write data |
| array_rdata | input | DATA_W | Data read from the memory array |
| erase_done | input | 1 | The erase engine finished successfully |
| erase_fail | input | 1 | The erase engine reports a failure |
| erase_start | output | 1 | One-cycle erase launch pulse |
| erase_chip | output | 1 | 1 = whole-chip erase, 0 = sector erase |
| erase_sector | output | ADDR_W-SECT_LSB | Sector number of the erase |
| abort_req | output | 1 | One-cycle abort request to the engine |
| busy | output | 1 | An erase is running or has failed without being cleared |
| rd_sel | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| rd_data | output | DATA_W | Read data for the selected source |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that `erase_done` and `erase_fail` arrive only while an erase is running, and never in the same cycle as each other. The bench keeps to all of this by using separate write, read and engine-report tasks, and each of those tasks drives exactly one strobe per cycle. The engine reports are raised only after the bench has seen `busy` go high.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2
  } rd_sel_e;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_UNL1  = 3'd1,
    SQ_UNL2  = 3'd2,
    SQ_SETUP = 3'd3,
    SQ_EUNL1 = 3'd4,
    SQ_EUNL2 = 3'd5
  } seq_e;

  typedef enum logic [1:0] {
    MD_ARRAY = 2'd0,
    MD_IDENT = 2'd1,
    MD_BUSY  = 2'd2,
    MD_FAIL  = 2'd3
  } mode_e;

  localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
  localparam logic [7:0] CMD_SETUP   = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_RESET   = 8'hF0;

  // Status byte: bit7 polling (0 while not ready), bit6 toggle, bit5 failure.
  function automatic logic [7:0] status_byte(input logic tog, input logic fail);
    return {1'b0, tog, fail, 5'b00000};
  endfunction

  // Identifier table indexed by the two lowest address bits.
  function automatic logic [15:0] ident_word(input logic [1:0] idx,
                                             input logic [15:0] mfr,
                                             input logic [15:0] dev);
    case (idx)
      2'b00:   return mfr;
      2'b01:   return dev;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/fcs_seq_track.sv
module fcs_seq_track
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned KEY_W  = 11,
  parameter int unsigned UNL_A1 = 'h555,
  parameter int unsigned UNL_A2 = 'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_byte,
  input  logic              hold,
  output logic              ev_chip,
  output logic              ev_sector,
  output logic              ev_ident,
  output logic              ev_reset,
  output logic              ev_break,
  output seq_e              seq_state
);

  localparam logic [KEY_W-1:0] KEY1 = UNL_A1[KEY_W-1:0];
  localparam logic [KEY_W-1:0] KEY2 = UNL_A2[KEY_W-1:0];

  seq_e st_q, st_d;
  logic at1, at2;

  assign at1 = (wr_addr[KEY_W-1:0] == KEY1);
  assign at2 = (wr_addr[KEY_W-1:0] == KEY2);

  always_comb begin
    st_d      = st_q;
    ev_chip   = 1'b0;
    ev_sector = 1'b0;
    ev_ident  = 1'b0;
    ev_reset  = 1'b0;
    ev_break  = 1'b0;
    if (wr_en) begin
      if (wr_byte == CMD_RESET) begin
        ev_reset = 1'b1;
        st_d     = SQ_IDLE;
      end else if (hold) begin
        st_d = SQ_IDLE;
      end else begin
        st_d = SQ_IDLE;
        case (st_q)
          SQ_IDLE: begin
            if (at1 && wr_byte == CMD_UNLOCK1) st_d = SQ_UNL1;
          end
          SQ_UNL1: begin
            if (at2 && wr_byte == CMD_UNLOCK2) st_d = SQ_UNL2;
            else ev_break = 1'b1;
          end
          SQ_UNL2: begin
            if (at1 && wr_byte == CMD_SETUP)      st_d = SQ_SETUP;
            else if (at1 && wr_byte == CMD_IDENT) ev_ident = 1'b1;
            else                                  ev_break = 1'b1;
          end
          SQ_SETUP: begin
            if (at1 && wr_byte == CMD_UNLOCK1) st_d = SQ_EUNL1;
            else ev_break = 1'b1;
          end
          SQ_EUNL1: begin
            if (at2 && wr_byte == CMD_UNLOCK2) st_d = SQ_EUNL2;
            else ev_break = 1'b1;
          end
          SQ_EUNL2: begin
            if (at1 && wr_byte == CMD_CHIP)  ev_chip = 1'b1;
            else if (wr_byte == CMD_SECTOR)  ev_sector = 1'b1;
            else                             ev_break = 1'b1;
          end
          default: ev_break = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign seq_state = st_q;

endmodule

// File: rtl/fcs_mode_ctrl.sv
module fcs_mode_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned SECT_LSB = 12,
  localparam int unsigned SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_chip,
  input  logic              ev_sector,
  input  logic              ev_ident,
  input  logic              ev_reset,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rd_en,
  input  logic              done_in,
  input  logic              fail_in,
  output mode_e             mode,
  output logic              tog,
  output logic              start,
  output logic              chip,
  output logic [SECT_W-1:0] sector,
  output logic              abort
);

  mode_e mode_q;
  logic  launch;

  assign launch = ev_chip | ev_sector;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MD_ARRAY;
      tog    <= 1'b0;
      start  <= 1'b0;
      chip   <= 1'b0;
      sector <= '0;
      abort  <= 1'b0;
    end else begin
      start <= 1'b0;
      abort <= 1'b0;
      case (mode_q)
        MD_ARRAY, MD_IDENT: begin
          if (launch) begin
            mode_q <= MD_BUSY;
            start  <= 1'b1;
            chip   <= ev_chip;
            sector <= ev_chip ? '0 : wr_addr[ADDR_W-1:SECT_LSB];
            tog    <= 1'b0;
          end else if (ev_ident) begin
            mode_q <= MD_IDENT;
          end else if (ev_reset) begin
            mode_q <= MD_ARRAY;
          end
        end
        MD_BUSY: begin
          if (ev_reset) begin
            abort  <= 1'b1;
            mode_q <= MD_ARRAY;
          end else if (fail_in) begin
            mode_q <= MD_FAIL;
          end else if (done_in) begin
            mode_q <= MD_ARRAY;
          end else if (rd_en) begin
            tog <= ~tog;
          end
        end
        default: begin
          if (ev_reset) begin
            abort  <= 1'b1;
            mode_q <= MD_ARRAY;
          end else if (rd_en) begin
            tog <= ~tog;
          end
        end
      endcase
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/fcs_read_mux.sv
module fcs_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter logic [15:0] MFR_CODE = 16'h00C2,
  parameter logic [15:0] DEV_CODE = 16'h2257
) (
  input  mode_e             mode,
  input  logic [1:0]        idx,
  input  logic [DATA_W-1:0] array_rdata,
  input  logic              tog,
  output logic [1:0]        sel,
  output logic [DATA_W-1:0] rd_data
);

  logic [15:0] id_w;
  logic [7:0]  st_b;

  assign id_w = ident_word(idx, MFR_CODE, DEV_CODE);
  assign st_b = status_byte(tog, mode == MD_FAIL);

  always_comb begin
    case (mode)
      MD_ARRAY: begin
        sel     = RD_ARRAY;
        rd_data = array_rdata;
      end
      MD_IDENT: begin
        sel     = RD_IDENT;
        rd_data = DATA_W'(id_w);
      end
      default: begin
        sel     = RD_STATUS;
        rd_data = DATA_W'(st_b);
      end
    endcase
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned KEY_W    = 11,
  parameter int unsigned SECT_LSB = 12,
  parameter int unsigned UNL_A1   = 'h555,
  parameter int unsigned UNL_A2   = 'h2AA,
  parameter logic [15:0] MFR_CODE = 16'h00C2,
  parameter logic [15:0] DEV_CODE = 16'h2257
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic [DATA_W-1:0]          array_rdata,
  input  logic                       erase_done,
  input  logic                       erase_fail,
  output logic                       erase_start,
  output logic                       erase_chip,
  output logic [ADDR_W-SECT_LSB-1:0] erase_sector,
  output logic                       abort_req,
  output logic                       busy,
  output logic [1:0]                 rd_sel,
  output logic [DATA_W-1:0]          rd_data
);

  // Named internal events, visible to the bound checker.
  logic  ev_chip, ev_sector, ev_ident, ev_reset, ev_break;
  logic  hold, tog;
  mode_e mode;
  seq_e  seq_state;

  assign hold = (mode == MD_BUSY) || (mode == MD_FAIL);
  assign busy = hold;

  fcs_seq_track #(
    .ADDR_W(ADDR_W), .KEY_W(KEY_W), .UNL_A1(UNL_A1), .UNL_A2(UNL_A2)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr), .wr_addr(bus_addr), .wr_byte(bus_wdata[7:0]),
    .hold(hold),
    .ev_chip(ev_chip), .ev_sector(ev_sector), .ev_ident(ev_ident),
    .ev_reset(ev_reset), .ev_break(ev_break), .seq_state(seq_state)
  );

  fcs_mode_ctrl #(
    .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)
  ) u_mode (
    .clk(clk), .rst_n(rst_n),
    .ev_chip(ev_chip), .ev_sector(ev_sector), .ev_ident(ev_ident),
    .ev_reset(ev_reset), .wr_addr(bus_addr), .rd_en(bus_rd),
    .done_in(erase_done), .fail_in(erase_fail),
    .mode(mode), .tog(tog), .start(erase_start), .chip(erase_chip),
    .sector(erase_sector), .abort(abort_req)
  );

  fcs_read_mux #(
    .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_rmux (
    .mode(mode), .idx(bus_addr[1:0]), .array_rdata(array_rdata), .tog(tog),
    .sel(rd_sel), .rd_data(rd_data)
  );

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 16,
  parameter logic [15:0] MFR_CODE = 16'h00C2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              erase_start,
  input logic              abort_req,
  input logic              busy,
  input logic [1:0]        rd_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              ev_break,
  input logic              ev_reset
);

  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> busy);

  a_r9_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !erase_start);

  a_r5_break_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    ev_break |=> !erase_start);

  a_r10_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req);

  a_r10_abort_to_array: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> (!busy && rd_sel == 2'd0));

  a_r10_abort_needs_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_req) |-> $past(ev_reset));

  a_r8_status_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_sel == 2'd2 && rd_data[7] == 1'b0));

  a_r6_mfr_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd1 && bus_addr[1:0] == 2'b00) |-> rd_data == DATA_W'(MFR_CODE));

  a_r8_tog_static: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(bus_rd)) |-> $stable(rd_data[6]));

endmodule

bind flash_cmd_seq fcs_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_CODE(MFR_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .erase_start(erase_start), .abort_req(abort_req), .busy(busy),
  .rd_sel(rd_sel), .rd_data(rd_data), .ev_break(ev_break), .ev_reset(ev_reset)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam int SL = 12;
  localparam logic [15:0] DEV = 16'h2257;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, array_rdata = '0;
  logic erase_done = 1'b0, erase_fail = 1'b0;
  logic erase_start, erase_chip, abort_req, busy;
  logic [AW-SL-1:0] erase_sector;
  logic [1:0] rd_sel;
  logic [DW-1:0] rd_data;

  always #2 clk = ~clk;

  flash_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .array_rdata(array_rdata),
    .erase_done(erase_done), .erase_fail(erase_fail),
    .erase_start(erase_start), .erase_chip(erase_chip),
    .erase_sector(erase_sector), .abort_req(abort_req), .busy(busy),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  int vecs = 0, errs = 0;
  bit finished = 0;

  // Reference model state
  int m_stage = 0;          // number of handshake writes matched so far
  int m_mode = 0;           // 0 array, 1 ident, 2 running, 3 failed
  bit m_tog = 0, m_start = 0, m_chip = 0, m_abort = 0;
  int m_sector = 0;
  int pat_addr[5] = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA};
  int pat_data[5] = '{'hAA, 'h55, 'h80, 'hAA, 'h55};
  string tag = "R1";

  task automatic chk(string req, string what, longint act, longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_rd();
    int a2 = int'(bus_addr[1:0]);
    if (m_mode == 0) return int'(array_rdata);
    if (m_mode == 1) return (a2 == 0) ? 'hC2 : (a2 == 1) ? int'(DEV) : 0;
    return (m_tog ? 64 : 0) + (m_mode == 3 ? 32 : 0);
  endfunction

  task automatic compare();
    chk(tag, "rd_sel", rd_sel, (m_mode >= 2) ? 2 : m_mode);
    chk(tag, "busy", busy, m_mode >= 2);
    chk(tag, "rd_data", rd_data, exp_rd());
    chk(tag, "erase_start", erase_start, m_start);
    chk(tag, "abort_req", abort_req, m_abort);
    if (m_start) begin
      chk(tag, "erase_chip", erase_chip, m_chip);
      chk(tag, "erase_sector", erase_sector, m_sector);
    end
  endtask

  task automatic model_edge();
    int a = int'(bus_addr) & 'h7FF;
    int d = int'(bus_wdata) & 'hFF;
    bit launch = 0;
    m_start = 0;
    m_abort = 0;
    if (bus_wr && d == 'hF0) begin
      if (m_mode >= 2) m_abort = 1;
      m_mode = 0;
      m_stage = 0;
    end else if (bus_wr && m_mode >= 2) begin
      m_stage = 0;
    end else if (bus_wr) begin
      if (m_stage == 2 && d == 'h90 && a == 'h555) begin
        m_mode = 1; m_stage = 0;
      end else if (m_stage == 5) begin
        if (d == 'h10 && a == 'h555) begin
          launch = 1; m_chip = 1; m_sector = 0;
        end else if (d == 'h30) begin
          launch = 1; m_chip = 0; m_sector = int'(bus_addr) >> SL;
        end
        m_stage = 0;
      end else if (d == pat_data[m_stage] && a == pat_addr[m_stage]) begin
        m_stage++;
      end else begin
        m_stage = 0;
      end
      if (launch) begin
        m_start = 1; m_mode = 2; m_tog = 0;
      end
    end else if (m_mode == 2 && erase_fail) begin
      m_mode = 3;
    end else if (m_mode == 2 && erase_done) begin
      m_mode = 0;
    end else if (m_mode >= 2 && bus_rd) begin
      m_tog = ~m_tog;
    end
  endtask

  task automatic cyc(bit w, bit r, int a, int d, bit dn, bit fl);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = AW'(a); bus_wdata = DW'(d);
    erase_done = dn; erase_fail = fl;
    array_rdata = DW'($urandom);
    #1;
    compare();
    @(posedge clk);
    model_edge();
  endtask

  task automatic wr(int a, int d); cyc(1, 0, a, d, 0, 0); endtask
  task automatic rd(int a);        cyc(0, 1, a, 0, 0, 0); endtask
  task automatic nop();            cyc(0, 0, 0, 0, 0, 0); endtask

  task automatic erase_seq(int fa, int fd);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr(fa, fd);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    tag = "R1"; nop(); nop();
    tag = "R2"; for (int i = 0; i < 4; i++) rd(i * 7);

    tag = "R6"; wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h90);
    for (int i = 0; i < 4; i++) rd(i);
    rd('h3C001); rd('h12300);
    tag = "R7"; rd(2); wr('h123, 'h00); rd(0); wr('h0, 'hF0); rd(0); rd(1);

    tag = "R3"; erase_seq('h555, 'h10); nop();
    tag = "R8"; for (int i = 0; i < 5; i++) rd(i); nop(); rd(0);
    tag = "R9"; erase_seq('h1000, 'h30); rd(0); nop();
    tag = "R11"; cyc(0, 0, 0, 0, 1, 0); rd(5); nop();

    tag = "R4"; erase_seq('h23456, 'h30); rd(0); rd(0);
    tag = "R11"; cyc(0, 0, 0, 0, 0, 1); rd(0); rd(0); wr('h555, 'hAA);
    tag = "R10"; wr('h77, 'hF0); nop(); rd(3);

    tag = "R5"; wr('h555, 'hAA); wr('h555, 'h55); wr('h555, 'h80); nop();
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80); wr('h554, 'hAA);
    wr('h2AA, 'h55); wr('h555, 'h10); nop();
    erase_seq('h555, 'h20); nop(); wr('h555, 'h10); nop();
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h91); rd(0);

    tag = "R12"; wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hF0);
    wr('h555, 'h80); wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h10); nop();

    tag = "R13"; wr('h3F555, 'h12AA); wr('h1_AAAA, 'hFF55); wr('h2_0555, 'h0080);
    wr('h555, 'h33AA); wr('h2AA, 'h0055); wr('h3_F800, 'hA530); nop();
    tag = "R10"; wr('h0, 'h12F0); nop(); rd(0);

    tag = "R6"; wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h90); rd(1);
    tag = "R3"; erase_seq('h555, 'h10); rd(0); cyc(0, 0, 0, 0, 1, 0); rd(0);
    tag = "R2"; for (int i = 0; i < 3; i++) rd(i);
    summary();
  end
endmodule